// File: doc/BRIEF.md
# Paged Packet Buffer Host Access Port

This block gives a byte-wide host port into a packet buffer split into equal pages. The host programs a 16-bit pointer register, written and read one byte at a time. It then moves bytes through a four-address data window. The pointer chooses the page source. One source is the page at the head of the receive queue and the other is the packet number supplied by the host. The pointer also holds the byte offset inside that page and decides whether each window access advances it. Page numbers come from queue and allocation logic outside this block and arrive as plain inputs.

Every access is one cycle wide. It is qualified by a chip select and by a register-bank selector that must equal the access bank. Reads return their byte on the cycle after the strobe. A 16-bit host access is issued as two byte accesses, at the address and at the address plus one. With the default parameters the buffer holds four pages of 2048 bytes each.

Top module: `pktbuf_access_port`

## Requirements
- R1: After reset the pointer is zero: reading either pointer byte returns 0x00, and `rd_valid` is low.
- R2: The pointer low byte is written at register address 6 and the high byte at address 7. Each write changes only its own eight bits.
- R3: Reading the pointer high byte returns the stored high byte ANDed with 0xF7. Reading the low byte returns it unchanged.
- R4: Pointer bit 15 set selects `rxq_head_page` as the page. Bit 15 clear selects `tx_pkt_page`.
- R5: With pointer bit 14 set, a window access uses the current offset (bits 10:0). After the access the offset becomes (offset+1) mod 2048, and bits 15:11 keep their value.
- R6: With pointer bit 14 clear, a window access leaves the pointer unchanged. The byte reached is (offset + address[1:0]) mod 2048.
- R7: A qualified read raises `rd_valid` with its byte in the next cycle only. `rd_valid` is low in every cycle that does not follow a qualified read.
- R8: An access with `cs` low or `bank_sel` not equal to 2 changes neither the pointer nor the buffer, and it produces no `rd_valid`.
- R9: The data window is the four addresses 8 to 11. Reads and writes map each address to the same byte.
- R10: Each page keeps every byte written to it, independently of the other pages.
- R11: A qualified read of any other address in the bank returns 0x00. A write to such an address changes neither the pointer nor the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for a host access |
| bank_sel | input | 2 | Current register bank; accesses act only when it is 2 |
| reg_addr | input | 4 | Byte address within the bank |
| wr_en | input | 1 | Write strobe (wins over `rd_en`) |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| rxq_head_page | input | 2 | Page at the head of the receive queue |
| tx_pkt_page | input | 2 | Host-selected packet page |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | Read byte is present this cycle |

## Verification
The bench builds the block with its default parameters: four pages of 2048 bytes. At that size every offset of every page is reachable. The bench fills each page completely through auto-increment writes and reads each page back twice, once per page source. This exercises the offset wrap from 2047 to 0 and checks that pages stay separate. Directed accesses cover the byte-lane sum wrapping past the page end, the masked high-byte read, and accesses that are unqualified or go to undecoded addresses.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int PTR_W    = 16;
  localparam int OFF_W    = 11;
  localparam int SRC_BIT  = 15;
  localparam int AUTO_BIT = 14;
  localparam logic [7:0] HI_READ_MASK = 8'hF7;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_PTR_LO = 2'd1,
    KIND_PTR_HI = 2'd2,
    KIND_WINDOW = 2'd3
  } acc_kind_e;

  // Offset field advances with wrap; control bits above it are kept.
  function automatic ptr_t ptr_advance(ptr_t p);
    off_t nxt;
    nxt = off_t'(p[OFF_W-1:0] + 1'b1);
    return {p[PTR_W-1:OFF_W], nxt};
  endfunction

  // Fixed-address mode: offset plus window lane, wrapped to the field.
  function automatic off_t lane_offset(ptr_t p, logic [1:0] lane);
    return off_t'(p[OFF_W-1:0] + off_t'(lane));
  endfunction
endpackage

// File: rtl/pba_ptr_reg.sv
module pba_ptr_reg
  import pba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_we,
  input  logic       hi_we,
  input  logic       step,
  input  logic [7:0] wdata,
  output ptr_t       ptr
);
  ptr_t ptr_q;
  ptr_t ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (lo_we)      ptr_d[7:0]  = wdata;
    else if (hi_we) ptr_d[15:8] = wdata;
    else if (step)  ptr_d = ptr_advance(ptr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5: the offset advances by one and the control bits hold
  a_r5_step_wraps_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_we && !hi_we) |=>
      (ptr[OFF_W-1:0] == off_t'($past(ptr[OFF_W-1:0]) + 11'd1)) &&
      (ptr[PTR_W-1:OFF_W] == $past(ptr[PTR_W-1:OFF_W])));

  // R2: a low-byte write leaves the high byte alone
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we) |=> (ptr[15:8] == $past(ptr[15:8])));

  // R2: a high-byte write leaves the low byte alone
  a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we) |=> (ptr[7:0] == $past(ptr[7:0])));
endmodule

// File: rtl/pba_addr_gen.sv
module pba_addr_gen
  import pba_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int IDX_W  = 11
) (
  input  ptr_t              ptr,
  input  logic [1:0]        lane,
  input  logic [PAGE_W-1:0] rxq_page,
  input  logic [PAGE_W-1:0] tx_page,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  off_t off_eff;

  always_comb begin
    page    = ptr[SRC_BIT] ? rxq_page : tx_page;
    off_eff = ptr[AUTO_BIT] ? ptr[OFF_W-1:0] : lane_offset(ptr, lane);
    idx     = off_eff[IDX_W-1:0];
  end
endmodule

// File: rtl/pba_page_ram.sv
module pba_page_ram #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int PAGE_W     = 2,
  parameter int IDX_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [PAGE_W-1:0] page,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [PAGES-1:0]  bank_we;
  logic [7:0]        bank_q [PAGES];
  logic [PAGE_W-1:0] page_q;

  for (genvar g = 0; g < PAGES; g++) begin : g_bank
    logic [7:0] mem [PAGE_BYTES];
    assign bank_we[g] = we && (page == PAGE_W'(g));
    always_ff @(posedge clk) begin
      if (bank_we[g]) mem[idx] <= wdata;
      if (re && (page == PAGE_W'(g))) bank_q[g] <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  page_q <= '0;
    else if (re) page_q <= page;
  end

  always_comb begin
    rdata = 8'h00;
    if (int'(page_q) < PAGES) rdata = bank_q[page_q];
  end

  // R10: a write never lands in more than one page
  a_r10_single_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
endmodule

// File: rtl/pktbuf_access_port.sv
module pktbuf_access_port
  import pba_pkg::*;
#(
  parameter int PAGES       = 4,
  parameter int PAGE_BYTES  = 2048,
  parameter int ADDR_W      = 4,
  parameter int BANK_W      = 2,
  parameter int ACCESS_BANK = 2,
  parameter int PTR_LO_ADDR = 6,
  parameter int PTR_HI_ADDR = 7,
  parameter int WIN_BASE    = 8,
  localparam int PAGE_W     = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int IDX_W      = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rxq_head_page,
  input  logic [PAGE_W-1:0] tx_pkt_page,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam logic [ADDR_W-3:0] WIN_TAG = (ADDR_W-2)'(WIN_BASE >> 2);

  logic      sel, do_wr, do_rd, win_hit, win_access;
  logic      ptr_lo_we, ptr_hi_we, ptr_step;
  acc_kind_e kind, kind_q;
  ptr_t      ptr_w;
  logic [7:0]        reg_byte_q;
  logic [PAGE_W-1:0] ram_page;
  logic [IDX_W-1:0]  ram_idx;
  logic [7:0]        ram_q;
  logic              rd_valid_q;

  // Access qualification and address decode
  always_comb begin
    sel        = cs && (bank_sel == BANK_W'(ACCESS_BANK));
    do_wr      = sel && wr_en;
    do_rd      = sel && rd_en && !wr_en;
    win_hit    = (reg_addr[ADDR_W-1:2] == WIN_TAG);
    win_access = (do_wr || do_rd) && win_hit;
    if (win_hit)                              kind = KIND_WINDOW;
    else if (reg_addr == ADDR_W'(PTR_LO_ADDR)) kind = KIND_PTR_LO;
    else if (reg_addr == ADDR_W'(PTR_HI_ADDR)) kind = KIND_PTR_HI;
    else                                      kind = KIND_NONE;
    ptr_lo_we = do_wr && (kind == KIND_PTR_LO);
    ptr_hi_we = do_wr && (kind == KIND_PTR_HI);
    ptr_step  = win_access && ptr_w[AUTO_BIT];
  end

  pba_ptr_reg u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_we (ptr_lo_we),
    .hi_we (ptr_hi_we),
    .step  (ptr_step),
    .wdata (wr_data),
    .ptr   (ptr_w)
  );

  pba_addr_gen #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_agen (
    .ptr      (ptr_w),
    .lane     (reg_addr[1:0]),
    .rxq_page (rxq_head_page),
    .tx_page  (tx_pkt_page),
    .page     (ram_page),
    .idx      (ram_idx)
  );

  pba_page_ram #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
  ) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (do_wr && win_hit),
    .re    (do_rd && win_hit),
    .page  (ram_page),
    .idx   (ram_idx),
    .wdata (wr_data),
    .rdata (ram_q)
  );

  // Read return stage: one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      kind_q     <= KIND_NONE;
      reg_byte_q <= 8'h00;
    end else begin
      rd_valid_q <= do_rd;
      if (do_rd) begin
        kind_q <= kind;
        case (kind)
          KIND_PTR_LO: reg_byte_q <= ptr_w[7:0];
          KIND_PTR_HI: reg_byte_q <= ptr_w[15:8] & HI_READ_MASK;
          default:     reg_byte_q <= 8'h00;
        endcase
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = (kind_q == KIND_WINDOW) ? ram_q : reg_byte_q;

  // R7: a qualified read yields exactly one valid cycle, the next one
  a_r7_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rd_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> !rd_valid);

  // R8: an unqualified access leaves the pointer untouched
  a_r8_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ptr_w));

  // R6: fixed-address window access leaves the pointer untouched
  a_r6_fixed_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_access && !ptr_w[AUTO_BIT]) |=> $stable(ptr_w));
endmodule

// File: tb/pktbuf_access_port_tb.sv
module pktbuf_access_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic [1:0] bank_sel = 2'd0;
  logic [3:0] reg_addr = 4'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rxq_head_page = 2'd0;
  logic [1:0] tx_pkt_page = 2'd0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] got;
  logic       got_v;

  always #2.5 clk = ~clk;

  pktbuf_access_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .bank_sel(bank_sel), .reg_addr(reg_addr),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rxq_head_page(rxq_head_page), .tx_pkt_page(tx_pkt_page),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] pat(int p, int i);
    int v;
    v = i * 7 + (i >> 8) * 3 + p * 61 + 1;
    return v[7:0];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic c, logic [1:0] b, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cs = c; bank_sel = b; reg_addr = a; wr_en = 1'b1; rd_en = 1'b0; wr_data = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(logic c, logic [1:0] b, logic [3:0] a);
    @(negedge clk);
    cs = c; bank_sel = b; reg_addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    got = rd_data; got_v = rd_valid;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_ptr(logic [15:0] p);
    wr(1'b1, 2'd2, 4'd6, p[7:0]);
    wr(1'b1, 2'd2, 4'd7, p[15:8]);
  endtask

  task automatic check_ptr(string req, logic [15:0] exp);
    rd(1'b1, 2'd2, 4'd6);
    check(req, got, exp[7:0]);
    rd(1'b1, 2'd2, 4'd7);
    check(req, got, exp[15:8] & 8'hF7);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    // R1: pointer is zero after reset
    check_ptr("R1", 16'h0000);

    // R2/R3: byte halves and masked high read
    wr(1'b1, 2'd2, 4'd6, 8'h5A);
    check_ptr("R2 lo write", 16'h005A);
    wr(1'b1, 2'd2, 4'd7, 8'h2C);
    check_ptr("R2 hi write", 16'h2C5A);
    wr(1'b1, 2'd2, 4'd7, 8'hFF);
    rd(1'b1, 2'd2, 4'd7);
    check("R3 hi mask", got, 8'hF7);
    rd(1'b1, 2'd2, 4'd6);
    check("R3 lo unmasked", got, 8'h5A);

    // R7: valid only in the cycle after a read
    @(negedge clk);
    check("R7 valid drops", {7'd0, rd_valid}, 8'h00);

    // R8: unqualified accesses ignored
    set_ptr(16'h0123);
    wr(1'b0, 2'd2, 4'd6, 8'hEE);
    wr(1'b1, 2'd1, 4'd7, 8'hEE);
    rd(1'b0, 2'd2, 4'd6);
    check("R8 no valid cs low", {7'd0, got_v}, 8'h00);
    rd(1'b1, 2'd3, 4'd6);
    check("R8 no valid wrong bank", {7'd0, got_v}, 8'h00);
    check_ptr("R8 ptr unchanged", 16'h0123);

    // R10/R5: fill every page with auto-increment writes
    for (int p = 0; p < 4; p++) begin
      tx_pkt_page = 2'(p);
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++) wr(1'b1, 2'd2, 4'(8 + (i % 4)), pat(p, i));
      check_ptr("R5 offset wraps to 0", 16'h4000);
    end
    // R10/R4: read back through packet number source
    for (int p = 0; p < 4; p++) begin
      tx_pkt_page = 2'(p);
      rxq_head_page = 2'(3 - p);
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++) begin
        rd(1'b1, 2'd2, 4'(8 + ((i + 1) % 4)));
        check("R10 tx source readback", got, pat(p, i));
        if (got_v !== 1'b1) check("R7 valid with data", {7'd0, got_v}, 8'h01);
      end
    end
    // R4: read back through receive-queue source
    for (int p = 0; p < 4; p++) begin
      rxq_head_page = 2'(p);
      tx_pkt_page = 2'(3 - p);
      set_ptr(16'hC000);
      for (int i = 0; i < 2048; i++) begin
        rd(1'b1, 2'd2, 4'd8);
        check("R4 rx source readback", got, pat(p, i));
      end
    end

    // R5: control bits kept across wrap
    tx_pkt_page = 2'd1;
    set_ptr(16'h5FFE);
    rd(1'b1, 2'd2, 4'd10);
    check("R5 byte 7FE", got, pat(1, 16'h7FE));
    rd(1'b1, 2'd2, 4'd9);
    check("R5 byte 7FF", got, pat(1, 16'h7FF));
    check_ptr("R5 control bits kept", 16'h5800);

    // R6/R9: fixed mode, lanes add to offset
    tx_pkt_page = 2'd2;
    set_ptr(16'h0010);
    for (int l = 0; l < 4; l++) begin
      rd(1'b1, 2'd2, 4'(8 + l));
      check("R9 read lane", got, pat(2, 16 + l));
    end
    check_ptr("R6 ptr unchanged", 16'h0010);
    wr(1'b1, 2'd2, 4'd9, 8'hC3);
    set_ptr(16'h07FE);
    wr(1'b1, 2'd2, 4'd11, 8'hA5);
    check_ptr("R6 ptr unchanged after write", 16'h07FE);
    set_ptr(16'h4001);
    rd(1'b1, 2'd2, 4'd8);
    check("R6 lane sum wraps", got, 8'hA5);
    set_ptr(16'h0011);
    rd(1'b1, 2'd2, 4'd8);
    check("R9 write lane", got, 8'hC3);
    rd(1'b1, 2'd2, 4'd10);
    check("R10 neighbour intact", got, pat(2, 19));

    // R11: undecoded addresses
    set_ptr(16'h0020);
    wr(1'b1, 2'd2, 4'd0, 8'h77);
    wr(1'b1, 2'd2, 4'd13, 8'h77);
    rd(1'b1, 2'd2, 4'd0);
    check("R11 read zero", got, 8'h00);
    check("R11 read valid", {7'd0, got_v}, 8'h01);
    check_ptr("R11 ptr unchanged", 16'h0020);
    rd(1'b1, 2'd2, 4'd8);
    check("R11 buffer unchanged", got, pat(2, 32));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule